// File: doc/BRIEF.md
# Partitioned 64-bit SIMD Integer Unit

This block runs one integer operation across a 64-bit word that is cut into independent lanes. A lane-size input selects eight 8-bit, four 16-bit or two 32-bit lanes. Carries, borrows and shifted-out bits never cross a lane boundary. The operations are lane-wise add and subtract with three overflow policies, a 16-bit lane multiply, three shift kinds, and two reshaping operations. Pack narrows lanes with saturation. Unpack interleaves lanes.

Each request arrives with `in_valid_i`. The result and an illegal-request flag are registered, and they come back exactly one cycle later with `out_valid_o`. Between requests the outputs hold their last value. Shift kinds use one shift count for every lane.

Top module: `simd_unit`

## Requirements
- R1: `lane_i` codes 0, 1 and 2 select 8-, 16- and 32-bit lanes. Code 3 is illegal for every operation: the result is zero and `illegal_o` is 1. A result that is flagged illegal is always zero.
- R2: `op_i` 0 adds and 1 subtracts (A minus B) per lane. With `sat_i` 0 or 3 the lane result wraps modulo 2^W, and no carry or borrow reaches a neighbouring lane.
- R3: With `sat_i` 1, add and subtract saturate as signed values, clamping to the lane's signed minimum or maximum.
- R4: With `sat_i` 2, add and subtract saturate as unsigned values: an add that overflows gives all ones, and a subtract that underflows gives zero.
- R5: `op_i` 2 multiplies 16-bit lanes (`lane_i` 1) and returns the low 16 bits of each product. Any other lane size gives zero and sets `illegal_o`.
- R6: `op_i` 3 shifts each lane left by `shamt_i`. A count of W or more gives zero.
- R7: `op_i` 4 shifts each lane right with zero fill. A count of W or more gives zero.
- R8: `op_i` 5 shifts each lane right with sign fill. A count of W or more fills the lane with its sign bit.
- R9: `op_i` 6 packs the W-bit lanes of A and B into W/2-bit lanes with signed saturation. A's lanes fill the low 32 bits in lane order, and B's lanes fill the high 32 bits. `lane_i` gives the source size: 1 packs 16 to 8, 2 packs 32 to 16, and 0 is illegal.
- R10: `op_i` 7 interleaves the low-half lanes of A and B. Result lane 2k is A lane k and result lane 2k+1 is B lane k.
- R11: `out_valid_o` equals `in_valid_i` from the previous clock. The result and flag update only on a clock with `in_valid_i` high, and otherwise hold.
- R12: While `rst_ni` is low, `out_valid_o`, `result_o` and `illegal_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| lane_i | input | 2 | Lane size code |
| sat_i | input | 2 | Add/subtract overflow policy |
| shamt_i | input | 6 | Shift count shared by all lanes |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| out_valid_o | output | 1 | Result valid, one cycle after the request |
| result_o | output | 64 | Registered result |
| illegal_o | output | 1 | Registered illegal-request flag |

## Verification
Each faulty lane slice or bad select shows up on `result_o` on the clock after the request, because the unit has only one register stage. A lane-boundary fault shows as a wrong value in exactly one lane. The operand patterns place carries, sign bits and saturation edges at every lane boundary for every size. A fault in the capture enable shows up one cycle later, when the operands change while the strobe is low and the held result must not move.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2, OP_SHL = 3'd3,
    OP_SHR = 3'd4, OP_SAR = 3'd5, OP_PACK = 3'd6, OP_UNPACK = 3'd7
  } simd_op_e;

  typedef enum logic [1:0] {LN_8 = 2'd0, LN_16 = 2'd1, LN_32 = 2'd2, LN_BAD = 2'd3} lane_sz_e;
  typedef enum logic [1:0] {SAT_WRAP = 2'd0, SAT_SIGNED = 2'd1, SAT_UNSIGNED = 2'd2, SAT_WRAP2 = 2'd3} sat_mode_e;
  typedef enum logic [1:0] {SH_LEFT = 2'd0, SH_LOGIC = 2'd1, SH_ARITH = 2'd2, SH_NONE = 2'd3} shift_kind_e;

  localparam int NUM_SZ      = 3;
  localparam int BASE_LANE_W = 8;
endpackage

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [1:0]        sat_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int NL  = DATA_W / LANE_W;
  localparam int MSB = LANE_W - 1;
  localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};

  sat_mode_e md;
  assign md = sat_mode_e'(sat_i);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LANE_W-1:0] ea, eb, r;
    logic [LANE_W:0]   s_sum, u_sum;

    assign ea = a_i[l*LANE_W +: LANE_W];
    assign eb = b_i[l*LANE_W +: LANE_W];
    assign s_sum = sub_i ? ({ea[MSB], ea} - {eb[MSB], eb}) : ({ea[MSB], ea} + {eb[MSB], eb});
    assign u_sum = sub_i ? ({1'b0, ea} - {1'b0, eb}) : ({1'b0, ea} + {1'b0, eb});

    always_comb begin
      unique case (md)
        SAT_SIGNED:
          r = (s_sum[LANE_W] != s_sum[MSB]) ? (s_sum[LANE_W] ? S_MIN : S_MAX) : s_sum[MSB:0];
        SAT_UNSIGNED:
          r = u_sum[LANE_W] ? (sub_i ? '0 : '1) : u_sum[MSB:0];
        default: r = u_sum[MSB:0];
      endcase
    end

    assign res_o[l*LANE_W +: LANE_W] = r;

    always_comb begin
      if (md == SAT_SIGNED && !sub_i && !ea[MSB] && !eb[MSB])
        AST_SSAT_NONNEG: assert (!r[MSB]); // R3
      if (md == SAT_UNSIGNED && !sub_i)
        AST_USAT_NO_DROP: assert (r >= ea); // R4
    end
  end
endmodule

// File: rtl/simd_shift.sv
module simd_shift
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int SH_W   = 6
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [1:0]        kind_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int NL  = DATA_W / LANE_W;
  localparam int AW  = $clog2(LANE_W);
  localparam int MSB = LANE_W - 1;

  shift_kind_e kind;
  logic        big;
  logic [AW-1:0] amt;

  assign kind = shift_kind_e'(kind_i);
  assign big  = int'(shamt_i) >= LANE_W;
  assign amt  = shamt_i[AW-1:0];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LANE_W-1:0] ea, r;
    assign ea = a_i[l*LANE_W +: LANE_W];

    always_comb begin
      unique case (kind)
        SH_LEFT:  r = big ? '0 : (ea << amt);
        SH_LOGIC: r = big ? '0 : (ea >> amt);
        SH_ARITH: r = big ? {LANE_W{ea[MSB]}} : LANE_W'($signed(ea) >>> amt);
        default:  r = ea;
      endcase
    end

    assign res_o[l*LANE_W +: LANE_W] = r;

    always_comb begin
      if (kind == SH_LOGIC) AST_LSR_NO_GROW: assert (r <= ea); // R7
      if (kind == SH_ARITH) AST_ASR_SIGN_KEPT: assert (r[MSB] == ea[MSB]); // R8
    end
  end
endmodule

// File: rtl/simd_mul.sv
module simd_mul #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int NL = DATA_W / LANE_W;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LANE_W-1:0] ea, eb, r;
    assign ea = a_i[l*LANE_W +: LANE_W];
    assign eb = b_i[l*LANE_W +: LANE_W];
    assign r  = ea * eb;  // low half of the product
    assign res_o[l*LANE_W +: LANE_W] = r;

    always_comb begin
      if (eb == LANE_W'(1)) AST_MUL_IDENTITY: assert (r == ea); // R5
    end
  end
endmodule

// File: rtl/simd_repack.sv
module simd_repack #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] pack_o,
  output logic [DATA_W-1:0] unpack_o
);
  localparam int NL   = DATA_W / LANE_W;
  localparam int HW   = LANE_W / 2;
  localparam int HALF = DATA_W / 2;

  function automatic logic [HW-1:0] narrow(input logic [LANE_W-1:0] v);
    if ((&v[LANE_W-1:HW-1]) || !(|v[LANE_W-1:HW-1])) return v[HW-1:0];
    return v[LANE_W-1] ? {1'b1, {(HW-1){1'b0}}} : {1'b0, {(HW-1){1'b1}}};
  endfunction

  for (genvar l = 0; l < NL; l++) begin : g_pack
    assign pack_o[l*HW +: HW]        = narrow(a_i[l*LANE_W +: LANE_W]);
    assign pack_o[HALF + l*HW +: HW] = narrow(b_i[l*LANE_W +: LANE_W]);

    always_comb begin
      AST_PACK_SIGN: assert (pack_o[l*HW + HW-1] == a_i[l*LANE_W + LANE_W-1]); // R9
    end
  end

  for (genvar l = 0; l < NL/2; l++) begin : g_unpack
    assign unpack_o[(2*l)*LANE_W +: LANE_W]   = a_i[l*LANE_W +: LANE_W];
    assign unpack_o[(2*l+1)*LANE_W +: LANE_W] = b_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/simd_unit.sv
module simd_unit
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SH_W   = 6,
  parameter int MUL_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [2:0]        op_i,
  input  logic [1:0]        lane_i,
  input  logic [1:0]        sat_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  localparam int MUL_SEL = $clog2(MUL_W / BASE_LANE_W);

  simd_op_e    op;
  lane_sz_e    ln;
  shift_kind_e kind;
  logic [1:0]  idx;
  logic        ill;
  logic [DATA_W-1:0] sel, mul_r;
  logic [DATA_W-1:0] add_r [NUM_SZ];
  logic [DATA_W-1:0] shf_r [NUM_SZ];
  logic [DATA_W-1:0] pck_r [NUM_SZ];
  logic [DATA_W-1:0] unp_r [NUM_SZ];

  logic              valid_q, ill_q;
  logic [DATA_W-1:0] result_q;

  assign op = simd_op_e'(op_i);
  assign ln = lane_sz_e'(lane_i);

  always_comb begin
    unique case (op)
      OP_SHL:  kind = SH_LEFT;
      OP_SHR:  kind = SH_LOGIC;
      OP_SAR:  kind = SH_ARITH;
      default: kind = SH_NONE;
    endcase
  end

  for (genvar g = 0; g < NUM_SZ; g++) begin : g_size
    localparam int LW = BASE_LANE_W << g;

    simd_addsub #(.DATA_W(DATA_W), .LANE_W(LW)) u_addsub (
      .a_i(a_i), .b_i(b_i), .sub_i(op == OP_SUB), .sat_i(sat_i), .res_o(add_r[g])
    );
    simd_shift #(.DATA_W(DATA_W), .LANE_W(LW), .SH_W(SH_W)) u_shift (
      .a_i(a_i), .shamt_i(shamt_i), .kind_i(kind), .res_o(shf_r[g])
    );
    simd_repack #(.DATA_W(DATA_W), .LANE_W(LW)) u_repack (
      .a_i(a_i), .b_i(b_i), .pack_o(pck_r[g]), .unpack_o(unp_r[g])
    );
  end

  simd_mul #(.DATA_W(DATA_W), .LANE_W(MUL_W)) u_mul (
    .a_i(a_i), .b_i(b_i), .res_o(mul_r)
  );

  assign idx = (ln == LN_BAD) ? 2'd0 : lane_i;
  assign ill = (ln == LN_BAD)
             || (op == OP_MUL && lane_i != 2'(MUL_SEL))
             || (op == OP_PACK && ln == LN_8);

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB:         sel = add_r[idx];
      OP_MUL:                 sel = mul_r;
      OP_SHL, OP_SHR, OP_SAR: sel = shf_r[idx];
      OP_PACK:                sel = pck_r[idx];
      default:                sel = unp_r[idx];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      ill_q    <= 1'b0;
      result_q <= '0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) begin
        ill_q    <= ill;
        result_q <= ill ? '0 : sel;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign result_o    = result_q;
  assign illegal_o   = ill_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o); // R11
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(result_o) && $stable(illegal_o))); // R11
  AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0)); // R1
  AST_MUL_LANE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && op_i == 3'd2 && lane_i != 2'd1) |=> illegal_o); // R5
endmodule

// File: tb/simd_unit_bench.sv
module simd_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [1:0]  lane, sat;
  logic [5:0]  shamt;
  logic [63:0] a, b;
  logic        out_valid, illegal;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  simd_unit u_simd_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op), .lane_i(lane),
    .sat_i(sat), .shamt_i(shamt), .a_i(a), .b_i(b),
    .out_valid_o(out_valid), .result_o(result), .illegal_o(illegal)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s op=%0d lane=%0d sat=%0d sh=%0d actual=%h expected=%h",
               req, what, op, lane, sat, shamt, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int i);
    case (i)
      0: return 64'h0;
      1: return 64'hFFFF_FFFF_FFFF_FFFF;
      2: return 64'h7F7F_7F7F_7F7F_7F7F;
      3: return 64'h8080_8080_8080_8080;
      4: return 64'h0123_4567_89AB_CDEF;
      5: return 64'h7FFF_8000_7FFF_FFFF;
      6: return 64'h8000_0001_0000_FF01;
      default: return 64'hC3A5_5A3C_0102_FE7F;
    endcase
  endfunction

  function automatic longint clamp(input longint v, input longint lo, input longint hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic void model(input int o, input int ln, input int st, input logic [63:0] xa,
                                input logic [63:0] xb, input int sh,
                                output logic [63:0] r, output logic il);
    int w, n, hw;
    longint mask, hmask, ea, eb, sa, sb, v, lo, hi;
    r = '0; il = 1'b0;
    if (ln == 3 || (o == 2 && ln != 1) || (o == 6 && ln == 0)) begin il = 1'b1; return; end
    w = 8 << ln; n = 64 / w; hw = w / 2;
    mask = (longint'(1) << w) - 1; hmask = (longint'(1) << hw) - 1;
    lo = -(longint'(1) << (w-1)); hi = (longint'(1) << (w-1)) - 1;
    for (int i = 0; i < n; i++) begin
      ea = longint'(xa >> (i*w)) & mask;
      eb = longint'(xb >> (i*w)) & mask;
      sa = ((ea >> (w-1)) & 1) != 0 ? ea - mask - 1 : ea;
      sb = ((eb >> (w-1)) & 1) != 0 ? eb - mask - 1 : eb;
      v = 0;
      case (o)
        0, 1: begin
          if (st == 1) v = clamp((o == 0) ? sa + sb : sa - sb, lo, hi);
          else begin
            v = (o == 0) ? ea + eb : ea - eb;
            if (st == 2) v = clamp(v, 0, mask);
          end
        end
        2: v = ea * eb;
        3: v = (sh >= w) ? 0 : (ea << sh);
        4: v = (sh >= w) ? 0 : (ea >> sh);
        5: v = (sh >= w) ? ((sa < 0) ? -1 : 0) : (sa >>> sh);
        default: v = 0;
      endcase
      if (o <= 5) r |= 64'(v & mask) << (i*w);
      else if (o == 6) begin
        r |= 64'(clamp(sa, -(longint'(1) << (hw-1)), (longint'(1) << (hw-1)) - 1) & hmask) << (i*hw);
        r |= 64'(clamp(sb, -(longint'(1) << (hw-1)), (longint'(1) << (hw-1)) - 1) & hmask) << (32 + i*hw);
      end else if (i < n/2) begin
        r |= 64'(ea) << (2*i*w);
        r |= 64'(eb) << ((2*i+1)*w);
      end
    end
  endfunction

  function automatic string req_of(input int o, input int ln, input int st);
    if (ln == 3) return "R1";
    case (o)
      0, 1: return (st == 1) ? "R3" : (st == 2) ? "R4" : "R2";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run(input int o, input int ln, input int st, input logic [63:0] xa,
                     input logic [63:0] xb, input int sh);
    logic [63:0] exp_r, held;
    logic exp_i, held_i;
    string rq;
    op = 3'(o); lane = 2'(ln); sat = 2'(st); a = xa; b = xb; shamt = 6'(sh);
    in_valid = 1'b1;
    model(o, ln, st, xa, xb, sh, exp_r, exp_i);
    rq = req_of(o, ln, st);
    @(negedge clk);
    check(rq, "result", result, exp_r);
    check(rq, "illegal", {63'd0, illegal}, {63'd0, exp_i});
    check("R11", "out_valid high", {63'd0, out_valid}, 64'd1);
    held = result; held_i = illegal;
    in_valid = 1'b0; a = ~xa; b = xb ^ 64'h5555_AAAA_3333_CCCC; op = op ^ 3'd1; shamt = 6'd1;
    @(negedge clk);
    check("R11", "out_valid low", {63'd0, out_valid}, 64'd0);
    check("R11", "result held", result, held);
    check("R11", "illegal held", {63'd0, illegal}, {63'd0, held_i});
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b1; op = 3'd0; lane = 2'd0; sat = 2'd0; shamt = '0;
    a = 64'hFFFF_FFFF_FFFF_FFFF; b = 64'h1;
    repeat (3) @(negedge clk);
    check("R12", "reset result", result, 64'd0);
    check("R12", "reset valid", {63'd0, out_valid}, 64'd0);
    check("R12", "reset illegal", {63'd0, illegal}, 64'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    for (int o = 0; o < 8; o++) begin
      for (int ln = 0; ln < 4; ln++) begin
        for (int st = 0; st < ((o <= 1) ? 4 : 1); st++) begin
          for (int ai = 0; ai < 8; ai++) begin
            for (int bi = 0; bi < ((o >= 3 && o <= 5) ? 1 : 8); bi++) begin
              if (o >= 3 && o <= 5) begin
                for (int si = 0; si < 13; si++) begin
                  int shs [13] = '{0, 1, 3, 7, 8, 9, 15, 16, 17, 31, 32, 33, 63};
                  run(o, ln, st, pat(ai), pat(7 - ai), shs[si]);
                end
              end else begin
                run(o, ln, st, pat(ai), pat(bi), 0);
              end
            end
          end
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule